// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block sits beside the storage array of a byte-wide parallel NOR flash and watches every bus write. It recognises the multi-cycle unlock sequences that start a byte program or a whole-chip erase, switch reads into identification mode, or cancel everything with a reset command. When a program or erase sequence completes, it emits a single-cycle start pulse. For a program, it also presents the target address and data captured from the final write. The embedded algorithm behind it reports that it is running through the `busy` input.

Reads are decoded combinationally. In array mode the array's byte passes straight through. In identification mode the decoder returns the manufacturer code, the device code, or the protection bit of the sector named by the upper read address bits. The write side has no back-pressure: each cycle with `wr_en` high is one bus write, and it is consumed in that cycle. The decoder cannot stall the host.

Top module: `flash_cmd_seq`

## Requirements
- R1: The writes AAh@555h, 55h@2AAh and A0h@555h, followed by any write (A, D), make `pgm_start` high for exactly the one cycle after that fourth write. In that cycle `op_addr`=A and `op_data`=D. The fourth write is always taken as program data, even when D is F0h.
- R2: The six writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh and 10h@555h make `erase_start` high for exactly the one cycle after the sixth write.
- R3: The writes AAh@555h, 55h@2AAh and 90h@555h set `id_mode` from the next cycle on. It stays set through any number of reads and idle cycles.
- R4: While `id_mode` is 1, `rd_data` depends on the low address byte of `rd_addr`. A value of 00h gives `MFR_CODE` (default 01h). A value of 01h gives `DEV_CODE` (default A4h). A value of 02h gives 01h if `sect_prot[s]` is 1 and 00h if it is 0, where s is the top `SECT_BITS` bits of `rd_addr`. Any other value gives 00h. All other address bits are ignored.
- R5: While `id_mode` is 0, `rd_data` equals `arr_rdata`.
- R6: A write of F0h at any address clears `id_mode` and returns the sequencer to idle. This applies in every sequence state except the program-data slot.
- R7: A write that does not match the next expected cycle returns the sequencer to idle. That write does not count as a first unlock cycle, so a full new sequence is needed.
- R8: A write made while `busy` is 1 is ignored. It changes neither the sequence state nor `id_mode`, and it raises no start pulse.
- R9: Unlock and command writes compare only the low 11 address bits. Upper address bits may hold any value.
- R10: During and after reset, the sequencer is idle. `id_mode`, `pgm_start` and `erase_start` are 0, and `op_addr` and `op_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One bus write per cycle while high |
| addr | input | AW | Write address |
| wdata | input | 8 | Write data |
| busy | input | 1 | Embedded program/erase is running |
| sect_prot | input | 2**SECT_BITS | Protection flag per sector |
| rd_addr | input | AW | Read address |
| arr_rdata | input | 8 | Byte from the storage array |
| rd_data | output | 8 | Read result |
| id_mode | output | 1 | Identification read mode active |
| pgm_start | output | 1 | One-cycle program start |
| erase_start | output | 1 | One-cycle chip erase start |
| op_addr | output | AW | Captured program address |
| op_data | output | 8 | Captured program data |

## Verification
A write is taken at the rising edge where `wr_en` is high. The start pulses, `id_mode`, `op_addr` and `op_data` all come from a single register stage, so a write's effect is visible in the next cycle. The start pulses are gone one cycle after that. `rd_data` is purely combinational and follows `rd_addr`, `arr_rdata` and `id_mode` in the same cycle. The bench drives each write on a falling edge and samples results on the following falling edge, which catches each pulse in its only high cycle. Read results are sampled a short delay after the read address changes.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam int UNLK_W = 11;

  localparam logic [UNLK_W-1:0] ADR_FIRST  = 11'h555;
  localparam logic [UNLK_W-1:0] ADR_SECOND = 11'h2AA;
  localparam logic [7:0] DAT_FIRST  = 8'hAA;
  localparam logic [7:0] DAT_SECOND = 8'h55;

  localparam logic [7:0] OPC_PROGRAM = 8'hA0;
  localparam logic [7:0] OPC_ERASE_SETUP = 8'h80;
  localparam logic [7:0] OPC_ERASE_CHIP = 8'h10;
  localparam logic [7:0] OPC_IDENT = 8'h90;
  localparam logic [7:0] OPC_RESET = 8'hF0;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_KEY1,
    SQ_KEY2,
    SQ_PGM_DATA,
    SQ_ER_SETUP,
    SQ_ER_KEY1,
    SQ_ER_KEY2
  } seq_state_t;

  typedef struct packed {
    logic key_first;
    logic key_second;
    logic cmd_slot;
    logic is_reset;
  } wr_class_t;

endpackage

// File: rtl/fcs_match.sv
module fcs_match
  import flash_seq_pkg::*;
(
  input  logic [UNLK_W-1:0] addr_lo,
  input  logic [7:0]        wdata,
  output wr_class_t         cls
);
  always_comb begin
    cls.key_first  = (addr_lo == ADR_FIRST)  && (wdata == DAT_FIRST);
    cls.key_second = (addr_lo == ADR_SECOND) && (wdata == DAT_SECOND);
    cls.cmd_slot   = (addr_lo == ADR_FIRST);
    cls.is_reset   = (wdata == OPC_RESET);
  end
endmodule

// File: rtl/fcs_seq.sv
module fcs_seq
  import flash_seq_pkg::*;
#(
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          busy,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  wr_class_t     cls,
  output logic          id_mode,
  output logic          pgm_start,
  output logic          erase_start,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_data
);
  seq_state_t state_q, state_d;
  logic fire_pgm, fire_erase, id_set, id_clr;
  logic take;

  assign take = wr_en && !busy;

  always_comb begin
    state_d    = state_q;
    fire_pgm   = 1'b0;
    fire_erase = 1'b0;
    id_set     = 1'b0;
    id_clr     = 1'b0;
    if (take) begin
      if (state_q == SQ_PGM_DATA) begin
        fire_pgm = 1'b1;
        state_d  = SQ_IDLE;
      end else if (cls.is_reset) begin
        id_clr  = 1'b1;
        state_d = SQ_IDLE;
      end else begin
        state_d = SQ_IDLE;
        case (state_q)
          SQ_IDLE:     if (cls.key_first)  state_d = SQ_KEY1;
          SQ_KEY1:     if (cls.key_second) state_d = SQ_KEY2;
          SQ_KEY2: begin
            if (cls.cmd_slot && wdata == OPC_PROGRAM)          state_d = SQ_PGM_DATA;
            else if (cls.cmd_slot && wdata == OPC_ERASE_SETUP) state_d = SQ_ER_SETUP;
            else if (cls.cmd_slot && wdata == OPC_IDENT)       id_set  = 1'b1;
          end
          SQ_ER_SETUP: if (cls.key_first)  state_d = SQ_ER_KEY1;
          SQ_ER_KEY1:  if (cls.key_second) state_d = SQ_ER_KEY2;
          SQ_ER_KEY2:  if (cls.cmd_slot && wdata == OPC_ERASE_CHIP) fire_erase = 1'b1;
          default:     state_d = SQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= SQ_IDLE;
      id_mode     <= 1'b0;
      pgm_start   <= 1'b0;
      erase_start <= 1'b0;
      op_addr     <= '0;
      op_data     <= '0;
    end else begin
      state_q     <= state_d;
      pgm_start   <= fire_pgm;
      erase_start <= fire_erase;
      if (id_set)      id_mode <= 1'b1;
      else if (id_clr) id_mode <= 1'b0;
      if (fire_pgm) begin
        op_addr <= addr;
        op_data <= wdata;
      end
    end
  end
endmodule

// File: rtl/fcs_id_read.sv
module fcs_id_read #(
  parameter int          AW        = 19,
  parameter int          SECT_BITS = 3,
  parameter logic [7:0]  MFR_CODE  = 8'h01,
  parameter logic [7:0]  DEV_CODE  = 8'hA4,
  localparam int         NSECT     = 1 << SECT_BITS
) (
  input  logic             id_mode,
  input  logic [AW-1:0]    rd_addr,
  input  logic [7:0]       arr_rdata,
  input  logic [NSECT-1:0] sect_prot,
  output logic [7:0]       rd_data
);
  logic prot_bit;
  logic [7:0] id_byte;

  generate
    if (SECT_BITS == 0) begin : g_single
      assign prot_bit = sect_prot[0];
      logic unused_hi;
      assign unused_hi = ^rd_addr[AW-1:8];
    end else begin : g_multi
      logic [SECT_BITS-1:0] sect_idx;
      assign sect_idx = rd_addr[AW-1 -: SECT_BITS];
      assign prot_bit = sect_prot[sect_idx];
      if (AW - SECT_BITS > 8) begin : g_mid
        logic unused_mid;
        assign unused_mid = ^rd_addr[AW-SECT_BITS-1:8];
      end
    end
  endgenerate

  always_comb begin
    case (rd_addr[7:0])
      8'h00:   id_byte = MFR_CODE;
      8'h01:   id_byte = DEV_CODE;
      8'h02:   id_byte = {7'd0, prot_bit};
      default: id_byte = 8'h00;
    endcase
    rd_data = id_mode ? id_byte : arr_rdata;
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int          AW        = 19,
  parameter int          SECT_BITS = 3,
  parameter logic [7:0]  MFR_CODE  = 8'h01,
  parameter logic [7:0]  DEV_CODE  = 8'hA4,
  localparam int         NSECT     = 1 << SECT_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [7:0]       wdata,
  input  logic             busy,
  input  logic [NSECT-1:0] sect_prot,
  input  logic [AW-1:0]    rd_addr,
  input  logic [7:0]       arr_rdata,
  output logic [7:0]       rd_data,
  output logic             id_mode,
  output logic             pgm_start,
  output logic             erase_start,
  output logic [AW-1:0]    op_addr,
  output logic [7:0]       op_data
);
  wr_class_t cls;

  fcs_match u_match (
    .addr_lo (addr[UNLK_W-1:0]),
    .wdata   (wdata),
    .cls     (cls)
  );

  fcs_seq #(.AW(AW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .busy        (busy),
    .addr        (addr),
    .wdata       (wdata),
    .cls         (cls),
    .id_mode     (id_mode),
    .pgm_start   (pgm_start),
    .erase_start (erase_start),
    .op_addr     (op_addr),
    .op_data     (op_data)
  );

  fcs_id_read #(
    .AW(AW), .SECT_BITS(SECT_BITS), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
  ) u_rd (
    .id_mode   (id_mode),
    .rd_addr   (rd_addr),
    .arr_rdata (arr_rdata),
    .sect_prot (sect_prot),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       busy,
  input logic [7:0] wdata,
  input logic       id_mode,
  input logic       pgm_start,
  input logic       erase_start
);
  // R1: a program start lasts a single cycle
  assert_pgm_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_start |=> !pgm_start);

  // R2: an erase start lasts a single cycle and never coincides with a program start
  assert_erase_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);
  assert_no_dual_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(pgm_start && erase_start));

  // R3: identification mode is only entered by an accepted 90h write
  assert_id_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_mode) |-> $past(wr_en && !busy && wdata == 8'h90));

  // R6: identification mode is only left through an accepted F0h write
  assert_id_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(id_mode) |-> $past(wr_en && !busy && wdata == 8'hF0));

  // R8: a write during busy starts nothing and leaves the mode alone
  assert_busy_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> (!pgm_start && !erase_start && $stable(id_mode)));
endmodule

bind flash_cmd_seq fcs_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .busy        (busy),
  .wdata       (wdata),
  .id_mode     (id_mode),
  .pgm_start   (pgm_start),
  .erase_start (erase_start)
);

// File: tb/sim_flash_cmd_seq.sv
`timescale 1ns/1ps
module sim_flash_cmd_seq;
  localparam int AW = 19;
  localparam int NV = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic busy = 1'b0;
  logic [7:0] sect_prot = 8'b1010_0100;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] arr_rdata = 8'h6B;
  logic [7:0] rd_data;
  logic id_mode, pgm_start, erase_start;
  logic [AW-1:0] op_addr;
  logic [7:0] op_data;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  flash_cmd_seq u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .busy(busy), .sect_prot(sect_prot), .rd_addr(rd_addr), .arr_rdata(arr_rdata),
    .rd_data(rd_data), .id_mode(id_mode), .pgm_start(pgm_start),
    .erase_start(erase_start), .op_addr(op_addr), .op_data(op_data)
  );

  // {req[4], wr, busy, addr[19], data[8], expect {pgm, erase, id}}
  localparam logic [35:0] VEC [NV] = '{
    {4'd1, 1'b1, 1'b0, 19'h00555, 8'hAA, 3'b000}, // R1 program
    {4'd1, 1'b1, 1'b0, 19'h002AA, 8'h55, 3'b000},
    {4'd1, 1'b1, 1'b0, 19'h00555, 8'hA0, 3'b000},
    {4'd1, 1'b1, 1'b0, 19'h12345, 8'h3C, 3'b100},
    {4'd1, 1'b0, 1'b0, 19'h00000, 8'h00, 3'b000},
    {4'd2, 1'b1, 1'b0, 19'h00555, 8'hAA, 3'b000}, // R2 chip erase
    {4'd2, 1'b1, 1'b0, 19'h002AA, 8'h55, 3'b000},
    {4'd2, 1'b1, 1'b0, 19'h00555, 8'h80, 3'b000},
    {4'd2, 1'b1, 1'b0, 19'h00555, 8'hAA, 3'b000},
    {4'd2, 1'b1, 1'b0, 19'h002AA, 8'h55, 3'b000},
    {4'd2, 1'b1, 1'b0, 19'h00555, 8'h10, 3'b010},
    {4'd2, 1'b0, 1'b0, 19'h00000, 8'h00, 3'b000},
    {4'd9, 1'b1, 1'b0, 19'h7F555, 8'hAA, 3'b000}, // R9 upper bits ignored
    {4'd9, 1'b1, 1'b0, 19'h7C2AA, 8'h55, 3'b000},
    {4'd9, 1'b1, 1'b0, 19'h40555, 8'hA0, 3'b000},
    {4'd1, 1'b1, 1'b0, 19'h00010, 8'hF0, 3'b100}, // R1 F0 taken as data
    {4'd3, 1'b1, 1'b0, 19'h00555, 8'hAA, 3'b000}, // R3 identification entry
    {4'd3, 1'b1, 1'b0, 19'h002AA, 8'h55, 3'b000},
    {4'd3, 1'b1, 1'b0, 19'h00555, 8'h90, 3'b001},
    {4'd3, 1'b0, 1'b0, 19'h00000, 8'h00, 3'b001},
    {4'd7, 1'b1, 1'b0, 19'h00555, 8'hAA, 3'b001}, // R7 mismatch
    {4'd7, 1'b1, 1'b0, 19'h002AB, 8'h55, 3'b001},
    {4'd7, 1'b1, 1'b0, 19'h002AA, 8'h55, 3'b001},
    {4'd7, 1'b1, 1'b0, 19'h00555, 8'hA0, 3'b001},
    {4'd7, 1'b1, 1'b0, 19'h00020, 8'h11, 3'b001},
    {4'd6, 1'b1, 1'b0, 19'h07777, 8'hF0, 3'b000}, // R6 reset command
    {4'd8, 1'b1, 1'b0, 19'h00555, 8'hAA, 3'b000}, // R8 busy writes ignored
    {4'd8, 1'b1, 1'b1, 19'h002AA, 8'h55, 3'b000},
    {4'd8, 1'b1, 1'b1, 19'h00000, 8'h77, 3'b000},
    {4'd8, 1'b1, 1'b0, 19'h002AA, 8'h55, 3'b000},
    {4'd8, 1'b1, 1'b0, 19'h00555, 8'hA0, 3'b000},
    {4'd8, 1'b1, 1'b0, 19'h00200, 8'h5A, 3'b100}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one write on a falling edge; return on the next falling edge
  task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d, input logic b);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; busy = b;
    @(negedge clk);
    wr_en = 1'b0; busy = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
    rd_addr = a;
    #1;
    chk(req, {24'd0, rd_data}, {24'd0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 start pulses/id", {29'd0, pgm_start, erase_start, id_mode}, 32'd0);
    chk("R10 op_addr", {13'd0, op_addr}, 32'd0);
    chk("R10 op_data", {24'd0, op_data}, 32'd0);
    rst_n = 1'b1;
    rd_chk("R5 array pass-through", 19'h00000, 8'h6B);

    for (int i = 0; i < NV; i++) begin
      logic [35:0] v;
      v = VEC[i];
      @(negedge clk);
      wr_en = v[31]; busy = v[30]; addr = v[29:11]; wdata = v[10:3];
      @(negedge clk);
      wr_en = 1'b0; busy = 1'b0;
      chk($sformatf("R%0d vector %0d", v[35:32], i),
          {29'd0, pgm_start, erase_start, id_mode}, {29'd0, v[2:0]});
    end
    chk("R8 op_addr after busy-interleaved program", {13'd0, op_addr}, 32'h00200);
    chk("R8 op_data after busy-interleaved program", {24'd0, op_data}, 32'h5A);

    // R1 captured address and data
    bus_wr(19'h00555, 8'hAA, 1'b0);
    bus_wr(19'h002AA, 8'h55, 1'b0);
    bus_wr(19'h00555, 8'hA0, 1'b0);
    bus_wr(19'h5A5A5, 8'hC3, 1'b0);
    chk("R1 pulse", {31'd0, pgm_start}, 32'd1);
    chk("R1 op_addr", {13'd0, op_addr}, 32'h5A5A5);
    chk("R1 op_data", {24'd0, op_data}, 32'hC3);
    @(negedge clk);
    chk("R1 pulse width", {31'd0, pgm_start}, 32'd0);

    // R3/R4 identification reads
    bus_wr(19'h00555, 8'hAA, 1'b0);
    bus_wr(19'h002AA, 8'h55, 1'b0);
    bus_wr(19'h00555, 8'h90, 1'b0);
    repeat (5) @(negedge clk);
    chk("R3 mode held", {31'd0, id_mode}, 32'd1);
    rd_chk("R4 manufacturer", {3'd7, 8'hFF, 8'h00}, 8'h01);
    rd_chk("R4 device", {3'd0, 8'h12, 8'h01}, 8'hA4);
    rd_chk("R4 protected sector 2", {3'd2, 8'h00, 8'h02}, 8'h01);
    rd_chk("R4 open sector 3", {3'd3, 8'h00, 8'h02}, 8'h00);
    rd_chk("R4 protected sector 5", {3'd5, 8'h40, 8'h02}, 8'h01);
    rd_chk("R4 other offset", {3'd5, 8'h00, 8'h05}, 8'h00);

    // R8 busy reset command ignored
    bus_wr(19'h00000, 8'hF0, 1'b1);
    chk("R8 busy F0 keeps mode", {31'd0, id_mode}, 32'd1);
    // R6 exit
    bus_wr(19'h01234, 8'hF0, 1'b0);
    chk("R6 mode cleared", {31'd0, id_mode}, 32'd0);
    rd_chk("R5 array after exit", {3'd0, 8'h00, 8'h00}, 8'h6B);

    // R6 reset mid-sequence abandons it
    bus_wr(19'h00555, 8'hAA, 1'b0);
    bus_wr(19'h002AA, 8'h55, 1'b0);
    bus_wr(19'h00555, 8'hF0, 1'b0);
    bus_wr(19'h00555, 8'hA0, 1'b0);
    bus_wr(19'h00300, 8'h44, 1'b0);
    chk("R6 no program after abandoned sequence", {31'd0, pgm_start}, 32'd0);

    // R10 reset clears identification mode
    bus_wr(19'h00555, 8'hAA, 1'b0);
    bus_wr(19'h002AA, 8'h55, 1'b0);
    bus_wr(19'h00555, 8'h90, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R10 mode after reset", {31'd0, id_mode}, 32'd0);
    chk("R10 op_addr after reset", {13'd0, op_addr}, 32'd0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule